// File: doc/BRIEF.md
# DMA Channel Status and Interrupt Aggregator

This block keeps one 32-bit control/status word per DMA channel and folds the event bits of all channels into a single interrupt line. A register bus writes each channel word. Depending on the bit position, a write loads a control bit, clears a status bit when a one is written, or sets or clears a status bit through a separate command bit. The channel engines and the request mapper send one-cycle event pulses, which raise the start, end, stop, request-after-stop and end-of-receive status bits.

Each channel drives a run-enable back to its engine. A read of a channel word ORs in the live peripheral request of that channel. One summary word at byte offset 0xF0 holds one bit per channel. A channel's bit is set while that channel has any source reaching the interrupt. Read data and the error flag are registered and appear one cycle after the access.

Top module: `dma_stat_agg`

## Requirements
- R1: After reset every channel word reads 0x00000008 (stop status only), every run_o bit is 0 and irq_o is 0.
- R2: A write loads bits 31..26 and bit 23 from the written data. Bits 22, 24 and 25 are command bits and are never stored. Bits 10..8 and 4..0 keep their old value unless another rule changes them.
- R3: Writing 1 to bit 9 (end-of-receive), bit 2 (end), bit 1 (start) or bit 0 (bus error) clears that status bit.
- R4: When bit 29 (stop irq enable) is set after a write, that write clears stop status (bit 3).
- R5: A write with bit 31 (run) set clears stop status. run_o[i] is high while channel i has run set and stop clear, so a stop event drops it.
- R6: A write with both bit 31 and bit 22 (mask-run) at 0 sets stop status, even when bit 29 is written as 1.
- R7: Written bit 24 clears compare status (bit 10) and written bit 25 sets it. When both are written as 1, bit 25 wins.
- R8: Event pulses set start (bit 1), end (bit 2), stop (bit 3), request-after-stop (bit 4) and end-of-receive (bit 9) on the next clock edge. An event wins over a clear of the same bit written in the same cycle.
- R9: Stop reaches the interrupt only when bit 29 is set, end-of-receive only when bit 28 is set, and request-after-stop only when bit 23 is set. Start and end always reach it. irq_o is high while any channel has a source that reaches it.
- R10: A read at byte offset 0xF0 returns bit i set when channel i has a source that reaches the interrupt.
- R11: Channel i sits at byte offset 4*i. A read returns the stored word with bit 8 set while req_active_i[i] is high.
- R12: An access to an unmapped or misaligned address gives bus_err_o=1 and bus_rdata_o=0 in the next cycle, and a write there changes no channel. A mapped access gives bus_err_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_re_i | input | 1 | Register read strobe |
| bus_addr_i | input | AW | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, one cycle after bus_re_i |
| bus_err_o | output | 1 | Unmapped or misaligned access, one cycle after the access |
| ev_start_i | input | NUM_CH | Start event pulses |
| ev_end_i | input | NUM_CH | End event pulses |
| ev_stop_i | input | NUM_CH | Stop event pulses |
| ev_ras_i | input | NUM_CH | Request-after-stop event pulses |
| ev_eor_i | input | NUM_CH | End-of-receive event pulses |
| req_active_i | input | NUM_CH | Live peripheral request per channel |
| run_o | output | NUM_CH | Run enable per channel |
| irq_o | output | 1 | Combined interrupt |

## Verification
The hardest case to reach from the ports is a write and an event that act on the same status bit in the same clock cycle. The stimulus raises the end event of a channel on the same falling edge that presents a write clearing that bit, and then reads the word back. Gated sources are tested the same way: the status bit is raised first with its enable clear, and the bench confirms that irq_o and the summary stay low. The enable is then written, and the bench confirms that the interrupt appears even though the status bit was not touched.

// File: rtl/dsa_pkg.sv
`timescale 1ns/1ps
package dsa_pkg;
  localparam int B_BUSERR  = 0;
  localparam int B_START   = 1;
  localparam int B_END     = 2;
  localparam int B_STOP    = 3;
  localparam int B_RAS     = 4;
  localparam int B_REQ     = 8;
  localparam int B_EOR     = 9;
  localparam int B_CMP     = 10;
  localparam int B_MASKRUN = 22;
  localparam int B_RASEN   = 23;
  localparam int B_CMPCLR  = 24;
  localparam int B_CMPSET  = 25;
  localparam int B_EOREN   = 28;
  localparam int B_STOPEN  = 29;
  localparam int B_RUN     = 31;

  localparam logic [31:0] KEEP_MASK = 32'h0000_071F;
  localparam logic [31:0] LOAD_MASK = 32'hFC80_0000;
  localparam logic [31:0] W1C_MASK  = 32'h0000_0207;
  localparam logic [31:0] RST_VAL   = 32'h0000_0008;
  localparam int          SUM_OFS   = 'hF0;

  typedef struct packed {
    logic start;
    logic fin;
    logic stop;
    logic ras;
    logic eor;
  } evt_t;
endpackage

// File: rtl/dsa_bus_dec.sv
`timescale 1ns/1ps
module dsa_bus_dec #(
  parameter int NUM_CH = 32,
  parameter int AW     = 8,
  localparam int IDX_W = $clog2(NUM_CH),
  localparam int WI    = AW - 2
) (
  input  logic [AW-1:0]    addr_i,
  input  logic             we_i,
  output logic [NUM_CH-1:0] wr_o,
  output logic             is_sum_o,
  output logic             unmapped_o,
  output logic [IDX_W-1:0] idx_o
);
  import dsa_pkg::*;

  logic [WI-1:0] word_idx;
  logic          aligned, hit_ch;

  assign word_idx   = addr_i[AW-1:2];
  assign aligned    = (addr_i[1:0] == 2'b00);
  assign hit_ch     = aligned && (word_idx < WI'(NUM_CH));
  assign is_sum_o   = aligned && (word_idx == WI'(SUM_OFS >> 2));
  assign unmapped_o = !hit_ch && !is_sum_o;
  assign idx_o      = word_idx[IDX_W-1:0];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_wr
    assign wr_o[i] = we_i && hit_ch && (word_idx == WI'(i));
  end
endmodule

// File: rtl/dsa_ch_csr.sv
`timescale 1ns/1ps
module dsa_ch_csr (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [31:0]   wdata_i,
  input  dsa_pkg::evt_t evt_i,
  output logic [31:0]   csr_o,
  output logic          run_o
);
  import dsa_pkg::*;

  logic [31:0] csr_q, csr_d;

  always_comb begin
    csr_d = csr_q;
    if (wr_i) begin
      csr_d = (csr_q & KEEP_MASK & ~(wdata_i & W1C_MASK)) | (wdata_i & LOAD_MASK);
      if (csr_d[B_STOPEN])                         csr_d[B_STOP] = 1'b0;
      if (wdata_i[B_RUN])                          csr_d[B_STOP] = 1'b0;
      if (!wdata_i[B_RUN] && !wdata_i[B_MASKRUN])  csr_d[B_STOP] = 1'b1;
      if (wdata_i[B_CMPCLR])                       csr_d[B_CMP]  = 1'b0;
      if (wdata_i[B_CMPSET])                       csr_d[B_CMP]  = 1'b1;
    end
    // events override same-cycle clears
    if (evt_i.start) csr_d[B_START] = 1'b1;
    if (evt_i.fin)   csr_d[B_END]   = 1'b1;
    if (evt_i.stop)  csr_d[B_STOP]  = 1'b1;
    if (evt_i.ras)   csr_d[B_RAS]   = 1'b1;
    if (evt_i.eor)   csr_d[B_EOR]   = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) csr_q <= RST_VAL;
    else         csr_q <= csr_d;
  end

  assign csr_o = csr_q;
  assign run_o = csr_q[B_RUN] & ~csr_q[B_STOP];

  // R3
  w1c_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && wdata_i[B_END] && !evt_i.fin |=> !csr_o[B_END]);
  // R5
  run_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_o) |-> $past(wr_i && wdata_i[B_RUN]));
  // R7
  cmp_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && wdata_i[B_CMPSET] |=> csr_o[B_CMP]);
  // R8
  stop_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.stop |=> csr_o[B_STOP] && !run_o);
endmodule

// File: rtl/dsa_irq_agg.sv
`timescale 1ns/1ps
module dsa_irq_agg #(
  parameter int NUM_CH = 32
) (
  input  logic [NUM_CH-1:0][31:0] csr_i,
  output logic [NUM_CH-1:0]       sum_o,
  output logic                    irq_o
);
  import dsa_pkg::*;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_src
    logic gated, ungated;
    assign gated   = (csr_i[i][B_STOP] & csr_i[i][B_STOPEN])
                   | (csr_i[i][B_EOR]  & csr_i[i][B_EOREN])
                   | (csr_i[i][B_RAS]  & csr_i[i][B_RASEN]);
    assign ungated = csr_i[i][B_START] | csr_i[i][B_END];
    assign sum_o[i] = gated | ungated;
  end

  assign irq_o = |sum_o;
endmodule

// File: rtl/dma_stat_agg.sv
`timescale 1ns/1ps
module dma_stat_agg #(
  parameter int NUM_CH = 32,
  parameter int AW     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [AW-1:0]     bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              bus_err_o,
  input  logic [NUM_CH-1:0] ev_start_i,
  input  logic [NUM_CH-1:0] ev_end_i,
  input  logic [NUM_CH-1:0] ev_stop_i,
  input  logic [NUM_CH-1:0] ev_ras_i,
  input  logic [NUM_CH-1:0] ev_eor_i,
  input  logic [NUM_CH-1:0] req_active_i,
  output logic [NUM_CH-1:0] run_o,
  output logic              irq_o
);
  import dsa_pkg::*;

  localparam int IDX_W = $clog2(NUM_CH);

  logic [NUM_CH-1:0]       wr_sel;
  logic                    is_sum, unmapped;
  logic [IDX_W-1:0]        idx;
  logic [NUM_CH-1:0][31:0] csr_all;
  logic [NUM_CH-1:0]       sum;
  logic [31:0]             ch_val, rd_val;

  dsa_bus_dec #(.NUM_CH(NUM_CH), .AW(AW)) u_dec (
    .addr_i     (bus_addr_i),
    .we_i       (bus_we_i),
    .wr_o       (wr_sel),
    .is_sum_o   (is_sum),
    .unmapped_o (unmapped),
    .idx_o      (idx)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    evt_t ev;
    assign ev = '{start: ev_start_i[i], fin: ev_end_i[i], stop: ev_stop_i[i],
                  ras: ev_ras_i[i], eor: ev_eor_i[i]};
    dsa_ch_csr u_csr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_sel[i]),
      .wdata_i (bus_wdata_i),
      .evt_i   (ev),
      .csr_o   (csr_all[i]),
      .run_o   (run_o[i])
    );
  end

  dsa_irq_agg #(.NUM_CH(NUM_CH)) u_agg (
    .csr_i (csr_all),
    .sum_o (sum),
    .irq_o (irq_o)
  );

  assign ch_val = csr_all[idx] | (32'(req_active_i[idx]) << B_REQ);
  assign rd_val = is_sum ? 32'(sum) : ch_val;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_rdata_o <= '0;
      bus_err_o   <= 1'b0;
    end else begin
      bus_rdata_o <= (bus_re_i && !unmapped) ? rd_val : '0;
      bus_err_o   <= (bus_re_i || bus_we_i) && unmapped;
    end
  end

  initial begin
    // summary word holds one bit per channel
    num_ch_chk: assert (NUM_CH >= 2 && NUM_CH <= 32);
  end

  // R12
  err_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_o |-> bus_rdata_o == '0);
  // R12
  err_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_err_o) |-> $past(bus_re_i || bus_we_i));
endmodule

// File: tb/tb_dma_stat_agg.sv
`timescale 1ns/1ps
module tb_dma_stat_agg;
  localparam int N  = 32;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_err;
  logic [N-1:0] ev_start = '0, ev_end = '0, ev_stop = '0, ev_ras = '0, ev_eor = '0;
  logic [N-1:0] req_act = '0;
  logic [N-1:0] run;
  logic irq;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  dma_stat_agg #(.NUM_CH(N), .AW(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_we_i(bus_we), .bus_re_i(bus_re), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .bus_err_o(bus_err),
    .ev_start_i(ev_start), .ev_end_i(ev_end), .ev_stop_i(ev_stop),
    .ev_ras_i(ev_ras), .ev_eor_i(ev_eor), .req_active_i(req_act),
    .run_o(run), .irq_o(irq)
  );

  typedef struct {
    logic [31:0] data;
    logic        err;
    logic        chk_data;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  logic acc_q = 1'b0;

  always @(posedge clk) acc_q <= rst_n && (bus_re || bus_we);

  // monitor: compare each access result against the queue head
  always @(negedge clk) begin
    if (acc_q) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL unexpected access result: actual rdata=%h err=%b expected none",
                 bus_rdata, bus_err);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (bus_err !== e.err || (e.chk_data && bus_rdata !== e.data)) begin
          bad++;
          $display("FAIL %s: actual rdata=%h err=%b expected rdata=%h err=%b",
                   e.tag, bus_rdata, bus_err, e.data, e.err);
        end
      end
    end
  end

  task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d,
                        input logic xerr, input string tag);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    exp_q.push_back('{data: 32'h0, err: xerr, chk_data: 1'b0, tag: tag});
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, input logic [31:0] xd,
                        input logic xerr, input string tag);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = a;
    exp_q.push_back('{data: xd, err: xerr, chk_data: 1'b1, tag: tag});
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic pulse(input int kind, input int ch);
    @(negedge clk);
    case (kind)
      0: ev_start[ch] = 1'b1;
      1: ev_end[ch]   = 1'b1;
      2: ev_stop[ch]  = 1'b1;
      3: ev_ras[ch]   = 1'b1;
      default: ev_eor[ch] = 1'b1;
    endcase
    @(negedge clk);
    ev_start = '0; ev_end = '0; ev_stop = '0; ev_ras = '0; ev_eor = '0;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] xp);
    total++;
    if (act !== xp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, xp);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 run_o", 32'(run), 32'h0);
    chk("R1 irq_o", 32'(irq), 32'h0);
    for (int i = 0; i < N; i++) bus_rd(AW'(4 * i), 32'h8, 1'b0, "R1 reset word");
    bus_rd(8'hF0, 32'h0, 1'b0, "R10 summary after reset");

    // R2 R6 load mask and stop on idle write
    bus_wr(8'h08, 32'h4080_0000, 1'b0, "R2 write");
    bus_rd(8'h08, 32'h4080_0008, 1'b0, "R2 R6 loaded bits");
    chk("R9 ras enable alone", 32'(irq), 32'h0);

    // R8 R9 R3 start and end ungated
    pulse(0, 1);
    pulse(1, 1);
    chk("R9 start/end irq", 32'(irq), 32'h1);
    bus_rd(8'hF0, 32'h2, 1'b0, "R10 summary ch1");
    bus_wr(8'h04, 32'h4, 1'b0, "R3 w1c end");
    bus_rd(8'h04, 32'hA, 1'b0, "R3 end cleared, start kept");
    chk("R9 start keeps irq", 32'(irq), 32'h1);
    bus_wr(8'h04, 32'h2, 1'b0, "R3 w1c start");
    bus_rd(8'h04, 32'h8, 1'b0, "R3 start cleared");
    chk("R9 irq low", 32'(irq), 32'h0);

    // R8 event beats same-cycle clear
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h4; ev_end[1] = 1'b1;
    exp_q.push_back('{data: 32'h0, err: 1'b0, chk_data: 1'b0, tag: "R8 collide write"});
    @(negedge clk);
    bus_we = 1'b0; ev_end = '0;
    bus_rd(8'h04, 32'hC, 1'b0, "R8 event wins over w1c");
    bus_wr(8'h04, 32'h4, 1'b0, "R3 cleanup");
    bus_rd(8'h04, 32'h8, 1'b0, "R3 end cleared");

    // R4 stop irq enable clears stop; R9 stop gated
    bus_wr(8'h0C, 32'h2040_0000, 1'b0, "R4 write");
    bus_rd(8'h0C, 32'h2000_0000, 1'b0, "R4 stop cleared");
    pulse(2, 3);
    bus_rd(8'h0C, 32'h2000_0008, 1'b0, "R8 stop event");
    chk("R9 stop enabled irq", 32'(irq), 32'h1);
    bus_rd(8'hF0, 32'h8, 1'b0, "R10 summary ch3");
    bus_wr(8'h0C, 32'h2040_0000, 1'b0, "R4 rewrite");
    chk("R4 irq gone", 32'(irq), 32'h0);

    // R6 stop set even with enable written
    bus_wr(8'h0C, 32'h2000_0000, 1'b0, "R6 write");
    bus_rd(8'h0C, 32'h2000_0008, 1'b0, "R6 stop set over enable");
    bus_wr(8'h0C, 32'h0040_0000, 1'b0, "R6 cleanup");

    // R5 run
    bus_wr(8'h10, 32'h8000_0000, 1'b0, "R5 run write");
    bus_rd(8'h10, 32'h8000_0000, 1'b0, "R5 stop cleared by run");
    chk("R5 run_o high", 32'(run), 32'h10);
    pulse(2, 4);
    chk("R5 run_o dropped", 32'(run), 32'h0);
    chk("R9 stop not enabled", 32'(irq), 32'h0);
    bus_rd(8'h10, 32'h8000_0008, 1'b0, "R5 run bit kept");
    bus_wr(8'h10, 32'h0, 1'b0, "R6 idle write");
    bus_rd(8'h10, 32'h8, 1'b0, "R6 stop set");

    // R7 compare
    bus_wr(8'h14, 32'h0240_0000, 1'b0, "R7 set");
    bus_rd(8'h14, 32'h0000_0408, 1'b0, "R7 compare set");
    bus_wr(8'h14, 32'h0140_0000, 1'b0, "R7 clear");
    bus_rd(8'h14, 32'h8, 1'b0, "R7 compare cleared");
    bus_wr(8'h14, 32'h0340_0000, 1'b0, "R7 both");
    bus_rd(8'h14, 32'h0000_0408, 1'b0, "R7 set wins");

    // R9 end-of-receive gated
    pulse(4, 6);
    chk("R9 eor ungated off", 32'(irq), 32'h0);
    bus_rd(8'h18, 32'h208, 1'b0, "R8 eor event");
    bus_wr(8'h18, 32'h1040_0000, 1'b0, "R9 eor enable");
    chk("R9 eor enabled irq", 32'(irq), 32'h1);
    bus_rd(8'h18, 32'h1000_0208, 1'b0, "R2 eor kept");
    bus_rd(8'hF0, 32'h40, 1'b0, "R10 summary ch6");
    bus_wr(8'h18, 32'h0040_0200, 1'b0, "R3 w1c eor");
    bus_rd(8'h18, 32'h8, 1'b0, "R3 eor cleared");
    chk("R9 irq low after eor", 32'(irq), 32'h0);

    // R9 request-after-stop gated
    pulse(3, 7);
    chk("R9 ras ungated off", 32'(irq), 32'h0);
    bus_rd(8'h1C, 32'h18, 1'b0, "R8 ras event");
    bus_wr(8'h1C, 32'h00C0_0000, 1'b0, "R9 ras enable");
    chk("R9 ras enabled irq", 32'(irq), 32'h1);
    bus_rd(8'hF0, 32'h80, 1'b0, "R10 summary ch7");
    bus_wr(8'h1C, 32'h0040_0000, 1'b0, "R9 ras disable");
    chk("R9 ras off again", 32'(irq), 32'h0);

    // R11 request pending
    @(negedge clk); req_act[8] = 1'b1;
    bus_rd(8'h20, 32'h108, 1'b0, "R11 request flag");
    bus_rd(8'hF0, 32'h0, 1'b0, "R10 request not a source");
    @(negedge clk); req_act[8] = 1'b0;
    bus_rd(8'h20, 32'h8, 1'b0, "R11 request released");

    // R12 unmapped and misaligned
    bus_rd(8'hF4, 32'h0, 1'b1, "R12 unmapped read");
    bus_rd(8'h80, 32'h0, 1'b1, "R12 past last channel");
    bus_rd(8'h09, 32'h0, 1'b1, "R12 misaligned read");
    bus_wr(8'h80, 32'h8000_0000, 1'b1, "R12 unmapped write");
    bus_rd(8'h00, 32'h8, 1'b0, "R12 ch0 untouched");
    chk("R12 run_o untouched", 32'(run), 32'h0);

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard: actual=%0d pending expected=0", exp_q.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule